// File: doc/BRIEF.md
# Amplifier power-up sequencer

This block steps a digital audio amplifier from its sleep state to driving audio and back again. When the power-up pin goes high, the block waits a wake-up interval. After that the control bus is declared usable. A settings window follows in which registers can be written while the clock generator is still stopped. The clock generator is then started and given a lock interval. Once the enable pin also allows it, the output stages are switched on. The demute request is raised only after a fixed number of sample periods in the active phase, and only while the mute-release input is high, so audio never rises before the volume path is ready.

All delays are counted in system clock ticks. The demute delay is counted in sample-rate strobes. The counts are parameters, so a system build can use real-time values and a test build can use short ones. Dropping the power-up pin cuts every output in the same cycle, with no clock edge needed. On the next edge the state machine returns to sleep.

Top module: `amp_pwrseq`

## Requirements
- R1: While reset is asserted, and after it is released, the phase is sleep (code 0) and all four control outputs are low, whatever the power-up pin does during reset.
- R2: When `pwr_up_i` is low, `phase_o` reads 0 and all four control outputs are low in that same cycle. After the next clock edge the internal state is sleep, so a later power-up restarts the full sequence from the wake phase.
- R3: The first edge that sees `pwr_up_i` high moves the phase to wake (code 1). Wake lasts exactly `WAKE_TICKS` cycles and is followed by bus-ready (code 2). In register-control mode (`ctrl_reg_i` = 1, sampled on leaving sleep), `bus_ready_o` is high in phases 2, 3 and 4 only.
- R4: Bus-ready lasts exactly `SETUP_TICKS` cycles and is followed by clock-running (code 3). `clk_start_o` is high in phases 3 and 4 only.
- R5: Clock-running lasts at least `LOCK_TICKS` cycles. The phase moves to active (code 4) on the first edge at which the lock time is complete and `enable_i` is high. `out_en_o` is high in phase 4 only.
- R6: A low `enable_i` during active returns the phase to clock-running on the next edge, and `out_en_o` goes low. When `enable_i` rises again, active is re-entered on the next edge with no new lock wait.
- R7: `demute_o` is high only in active, only after `MUTE_FS` sample strobes have been counted since the latest entry into active, and only while `mute_off_i` is high. It follows `mute_off_i` in the same cycle.
- R8: In pin-strapped mode (`ctrl_reg_i` = 0 when leaving sleep), the phase timing is unchanged and `bus_ready_o` stays low throughout.
- R9: The turn-on time `WAKE_TICKS + SETUP_TICKS + LOCK_TICKS` must lie within [`TON_MIN_TICKS`, `TON_MAX_TICKS`], and `MUTE_FS` must not exceed 128; elaboration rejects other values. With `enable_i` held high, `out_en_o` rises exactly that many cycles after the wake phase begins.
- R10: The phase only moves forward by one code, drops to sleep, or steps from active back to clock-running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_up_i | input | 1 | Power-up pin: 1 = run, 0 = sleep |
| enable_i | input | 1 | Enable pin gating the output stages |
| ctrl_reg_i | input | 1 | Control mode: 1 = register-controlled, 0 = pin-strapped |
| fs_tick_i | input | 1 | One-cycle strobe per audio sample period |
| mute_off_i | input | 1 | Mute released (soft-mute bit or volume pin level) |
| bus_ready_o | output | 1 | Control bus may be used |
| clk_start_o | output | 1 | Start the clock generator |
| out_en_o | output | 1 | Enable the output stages |
| demute_o | output | 1 | Request the demute ramp |
| phase_o | output | 3 | Current phase: 0 sleep, 1 wake, 2 bus-ready, 3 clock-running, 4 active |

## Verification
The bench builds the block with a wake time of 5, a settings window of 7, a lock time of 4 and a demute count of 3, with turn-on bounds of 12 to 20. These values keep every phase boundary within a few dozen cycles. They let directed tests reach exact transition edges, the hold in clock-running, and re-entry into active. A long random run with frequent power drops, enable toggles and mute changes also becomes affordable. Because the demute count is small, the restart of the sample count after each return to active is hit many times during that run.

// File: rtl/amp_pwrseq_pkg.sv
package amp_pwrseq_pkg;

   // Phase codes are visible on phase_o; the order is the power-up order.
   typedef enum logic [2:0] {
      PH_SLEEP  = 3'd0,
      PH_WAKE   = 3'd1,
      PH_BUSRDY = 3'd2,
      PH_CLKRUN = 3'd3,
      PH_ACTIVE = 3'd4
   } phase_e;

   localparam int unsigned MAX_MUTE_FS = 128;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/amp_pwrseq_timer.sv
// Saturating event counter. EARLY selects whether the flag also fires on the
// event that reaches the limit (used for phase hand-over in the same edge).
module amp_pwrseq_timer #(
   parameter int unsigned CNT_W = 8,
   parameter bit          EARLY = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] lim_i,
   output logic             flag_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_lim;

   assign at_lim = (cnt_q == lim_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && !at_lim) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   generate
      if (EARLY) begin : g_early
         logic hit_now;
         assign hit_now = inc_i && (cnt_q == (lim_i - CNT_W'(1)));
         assign flag_o  = hit_now || at_lim;
      end else begin : g_plain
         assign flag_o = at_lim;
      end
   endgenerate

endmodule

// File: rtl/amp_pwrseq_fsm.sv
module amp_pwrseq_fsm
   import amp_pwrseq_pkg::*;
#(
   parameter int unsigned WAKE_TICKS  = 40,
   parameter int unsigned SETUP_TICKS = 660,
   parameter int unsigned LOCK_TICKS  = 300,
   parameter int unsigned MUTE_FS     = 128
) (
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   pwr_up_i,
   input  logic   enable_i,
   input  logic   ctrl_reg_i,
   input  logic   fs_tick_i,
   output phase_e phase_o,
   output logic   reg_mode_o,
   output logic   fs_done_o
);

   localparam int unsigned MAX_TICKS = max3(WAKE_TICKS, SETUP_TICKS, LOCK_TICKS);
   localparam int unsigned T_W       = $clog2(MAX_TICKS + 1);
   localparam int unsigned F_W       = $clog2(MUTE_FS + 1);

   phase_e         phase_q, phase_d;
   logic           mode_q;
   logic           t_clr, t_inc, t_flag;
   logic [T_W-1:0] t_lim;
   logic           lock_ok;

   // Phase timer: one counter reused by wake, settings window and lock wait.
   amp_pwrseq_timer #(
      .CNT_W (T_W),
      .EARLY (1'b1)
   ) u_phase_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (t_clr),
      .inc_i  (t_inc),
      .lim_i  (t_lim),
      .flag_o (t_flag)
   );

   // Sample-period timer: restarts whenever active is left.
   amp_pwrseq_timer #(
      .CNT_W (F_W),
      .EARLY (1'b0)
   ) u_fs_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (phase_q != PH_ACTIVE),
      .inc_i  (fs_tick_i),
      .lim_i  (F_W'(MUTE_FS)),
      .flag_o (fs_done_o)
   );

   assign lock_ok = t_flag;

   always_comb begin
      phase_d = phase_q;
      t_clr   = 1'b0;
      t_inc   = 1'b0;
      t_lim   = T_W'(LOCK_TICKS);
      unique case (phase_q)
         PH_SLEEP: begin
            t_clr = 1'b1;
            phase_d = PH_WAKE;
         end
         PH_WAKE: begin
            t_inc = 1'b1;
            t_lim = T_W'(WAKE_TICKS);
            if (t_flag) begin
               phase_d = PH_BUSRDY;
               t_clr   = 1'b1;
            end
         end
         PH_BUSRDY: begin
            t_inc = 1'b1;
            t_lim = T_W'(SETUP_TICKS);
            if (t_flag) begin
               phase_d = PH_CLKRUN;
               t_clr   = 1'b1;
            end
         end
         PH_CLKRUN: begin
            t_inc = 1'b1;
            if (lock_ok && enable_i) begin
               phase_d = PH_ACTIVE;
            end
         end
         PH_ACTIVE: begin
            if (!enable_i) begin
               phase_d = PH_CLKRUN;
            end
         end
         default: begin
            phase_d = PH_SLEEP;
            t_clr   = 1'b1;
         end
      endcase
      if (!pwr_up_i) begin
         phase_d = PH_SLEEP;
         t_clr   = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_SLEEP;
         mode_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_SLEEP && pwr_up_i) begin
            mode_q <= ctrl_reg_i;
         end
      end
   end

   assign phase_o    = phase_q;
   assign reg_mode_o = mode_q;

endmodule

// File: rtl/amp_pwrseq_gate.sv
// Output stage: every control is qualified by the live power-up level so
// that sleep takes effect without waiting for a clock edge.
module amp_pwrseq_gate
   import amp_pwrseq_pkg::*;
(
   input  logic       pwr_up_i,
   input  logic       mute_off_i,
   input  phase_e     phase_i,
   input  logic       reg_mode_i,
   input  logic       fs_done_i,
   output logic       bus_ready_o,
   output logic       clk_start_o,
   output logic       out_en_o,
   output logic       demute_o,
   output logic [2:0] phase_o
);

   logic past_wake, clk_on, active;

   assign past_wake = (phase_i == PH_BUSRDY) || (phase_i == PH_CLKRUN) ||
                      (phase_i == PH_ACTIVE);
   assign clk_on    = (phase_i == PH_CLKRUN) || (phase_i == PH_ACTIVE);
   assign active    = (phase_i == PH_ACTIVE);

   assign bus_ready_o = pwr_up_i && reg_mode_i && past_wake;
   assign clk_start_o = pwr_up_i && clk_on;
   assign out_en_o    = pwr_up_i && active;
   assign demute_o    = pwr_up_i && active && fs_done_i && mute_off_i;
   assign phase_o     = pwr_up_i ? phase_i : PH_SLEEP;

endmodule

// File: rtl/amp_pwrseq.sv
module amp_pwrseq
   import amp_pwrseq_pkg::*;
#(
   parameter int unsigned WAKE_TICKS    = 40,
   parameter int unsigned SETUP_TICKS   = 660,
   parameter int unsigned LOCK_TICKS    = 300,
   parameter int unsigned TON_MIN_TICKS = 700,
   parameter int unsigned TON_MAX_TICKS = 1350,
   parameter int unsigned MUTE_FS       = 128
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       pwr_up_i,
   input  logic       enable_i,
   input  logic       ctrl_reg_i,
   input  logic       fs_tick_i,
   input  logic       mute_off_i,
   output logic       bus_ready_o,
   output logic       clk_start_o,
   output logic       out_en_o,
   output logic       demute_o,
   output logic [2:0] phase_o
);

   localparam int unsigned TON_TICKS = WAKE_TICKS + SETUP_TICKS + LOCK_TICKS;

   // R9: parameter legality
   generate
      if (WAKE_TICKS < 1 || SETUP_TICKS < 1 || LOCK_TICKS < 1) begin : g_bad_ticks
         $error("amp_pwrseq: every phase needs at least one tick");
      end
      if (MUTE_FS < 1 || MUTE_FS > MAX_MUTE_FS) begin : g_bad_fs
         $error("amp_pwrseq: MUTE_FS out of range");
      end
      if (TON_TICKS < TON_MIN_TICKS || TON_TICKS > TON_MAX_TICKS) begin : g_bad_ton
         $error("amp_pwrseq: turn-on time outside its window");
      end
   endgenerate

   phase_e phase_s;
   logic   reg_mode_s;
   logic   fs_done_s;

   amp_pwrseq_fsm #(
      .WAKE_TICKS  (WAKE_TICKS),
      .SETUP_TICKS (SETUP_TICKS),
      .LOCK_TICKS  (LOCK_TICKS),
      .MUTE_FS     (MUTE_FS)
   ) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pwr_up_i   (pwr_up_i),
      .enable_i   (enable_i),
      .ctrl_reg_i (ctrl_reg_i),
      .fs_tick_i  (fs_tick_i),
      .phase_o    (phase_s),
      .reg_mode_o (reg_mode_s),
      .fs_done_o  (fs_done_s)
   );

   amp_pwrseq_gate u_gate (
      .pwr_up_i    (pwr_up_i),
      .mute_off_i  (mute_off_i),
      .phase_i     (phase_s),
      .reg_mode_i  (reg_mode_s),
      .fs_done_i   (fs_done_s),
      .bus_ready_o (bus_ready_o),
      .clk_start_o (clk_start_o),
      .out_en_o    (out_en_o),
      .demute_o    (demute_o),
      .phase_o     (phase_o)
   );

endmodule

// File: rtl/amp_pwrseq_chk.sv
module amp_pwrseq_chk #(
   parameter int unsigned WAKE_TICKS  = 40,
   parameter int unsigned SETUP_TICKS = 660
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       pwr_up_i,
   input logic       enable_i,
   input logic       mute_off_i,
   input logic       bus_ready_o,
   input logic       clk_start_o,
   input logic       out_en_o,
   input logic       demute_o,
   input logic [2:0] phase_o
);

   logic [2:0] ph_prev;
   int         run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_prev <= 3'd0;
         run_q   <= 0;
      end else begin
         ph_prev <= phase_o;
         run_q   <= (phase_o == ph_prev) ? run_q + 1 : 1;
      end
   end

   AST_SLEEP_CUTS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_up_i |-> (phase_o == 3'd0) && !bus_ready_o && !clk_start_o &&
                    !out_en_o && !demute_o); // R2

   AST_WAKE_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == 3'd2 && ph_prev == 3'd1) |-> run_q == int'(WAKE_TICKS)); // R3

   AST_BUS_AFTER_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_ready_o |-> phase_o >= 3'd2); // R3

   AST_SETUP_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == 3'd3 && ph_prev == 3'd2) |-> run_q == int'(SETUP_TICKS)); // R4

   AST_OUT_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_en_o |-> clk_start_o && phase_o == 3'd4); // R5

   AST_ENABLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == 3'd4 && !enable_i && pwr_up_i) |=> !out_en_o); // R6

   AST_DEMUTE_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      demute_o |-> out_en_o && mute_off_i); // R7

   AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o != ph_prev) |-> (phase_o == 3'd0) || (phase_o == ph_prev + 3'd1) ||
                               (ph_prev == 3'd4 && phase_o == 3'd3)); // R10

endmodule

bind amp_pwrseq amp_pwrseq_chk #(
   .WAKE_TICKS  (WAKE_TICKS),
   .SETUP_TICKS (SETUP_TICKS)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .pwr_up_i    (pwr_up_i),
   .enable_i    (enable_i),
   .mute_off_i  (mute_off_i),
   .bus_ready_o (bus_ready_o),
   .clk_start_o (clk_start_o),
   .out_en_o    (out_en_o),
   .demute_o    (demute_o),
   .phase_o     (phase_o)
);

// File: tb/test_amp_pwrseq.sv
module test_amp_pwrseq;

   localparam int W = 5, S = 7, L = 4, F = 3, TMIN = 12, TMAX = 20;

   logic clk = 1'b0;
   logic rst_n, pwr, en, mode, fs, mute;
   logic bus, clks, oe, dm;
   logic [2:0] ph;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   amp_pwrseq #(
      .WAKE_TICKS (W), .SETUP_TICKS (S), .LOCK_TICKS (L),
      .TON_MIN_TICKS (TMIN), .TON_MAX_TICKS (TMAX), .MUTE_FS (F)
   ) i_amp_pwrseq (
      .clk_i (clk), .rst_ni (rst_n), .pwr_up_i (pwr), .enable_i (en),
      .ctrl_reg_i (mode), .fs_tick_i (fs), .mute_off_i (mute),
      .bus_ready_o (bus), .clk_start_o (clks), .out_en_o (oe),
      .demute_o (dm), .phase_o (ph)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic go(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_fs();
      #5 fs = 1'b1;
      @(negedge clk);
      #5 fs = 1'b0;
      @(negedge clk);
   endtask

   // Behavioural reference model, advanced on every rising edge.
   int m_ph = 0, m_cnt = 0, m_fs = 0;
   bit m_mode = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_fs = 0; m_mode = 1'b0;
      end else begin
         if (m_ph == 4) begin
            if (fs && m_fs < F) m_fs++;
         end else begin
            m_fs = 0;
         end
         if (!pwr) begin
            m_ph = 0; m_cnt = 0;
         end else begin
            case (m_ph)
               0: begin m_ph = 1; m_cnt = 0; m_mode = mode; end
               1: if (m_cnt == W - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
               2: if (m_cnt == S - 1) begin m_ph = 3; m_cnt = 0; end else m_cnt++;
               3: begin
                  bit lock_ok;
                  lock_ok = (m_cnt >= L - 1);
                  if (m_cnt < L) m_cnt++;
                  if (lock_ok && en) m_ph = 4;
               end
               default: if (!en) m_ph = 3;
            endcase
         end
      end
   end

   // Cycle-by-cycle comparison, away from the rising edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         int e_ph;
         bit e_bus, e_clk, e_oe, e_dm;
         e_ph  = pwr ? m_ph : 0;
         e_bus = pwr && m_mode && m_ph >= 2;
         e_clk = pwr && m_ph >= 3;
         e_oe  = pwr && m_ph == 4;
         e_dm  = e_oe && m_fs >= F && mute;
         if (!pwr) chk("R2 model outputs", {ph, bus, clks, oe, dm}, 0);
         else begin
            chk("R10 model phase", ph, e_ph);
            chk("R3 model bus_ready", bus, e_bus);
            chk("R4 model clk_start", clks, e_clk);
            chk("R5 model out_en", oe, e_oe);
            chk("R7 model demute", dm, e_dm);
         end
      end
   end

   initial begin
      rst_n = 1'b0; pwr = 1'b1; en = 1'b0; mode = 1'b1; fs = 1'b0; mute = 1'b0;
      go(3);
      chk("R1 phase in reset", ph, 0);
      chk("R1 outputs in reset", {bus, clks, oe, dm}, 0);
      #5 pwr = 1'b0; rst_n = 1'b1;
      go(1);
      chk("R1 phase after reset", ph, 0);

      // Register-controlled power-up with enable and mute released.
      #5 pwr = 1'b1; en = 1'b1; mute = 1'b1; mode = 1'b1;
      go(1);
      chk("R3 wake phase", ph, 1);
      chk("R3 bus not yet ready", bus, 0);
      go(W);
      chk("R3 bus-ready phase", ph, 2);
      chk("R3 bus_ready high", bus, 1);
      chk("R4 clock still stopped", clks, 0);
      go(S);
      chk("R4 clock-running phase", ph, 3);
      chk("R4 clk_start high", clks, 1);
      chk("R5 outputs still off", oe, 0);
      go(L);
      chk("R5 active phase", ph, 4);
      chk("R5 out_en high", oe, 1);
      chk("R7 demute waits", dm, 0);
      for (int i = 0; i < F - 1; i++) pulse_fs();
      chk("R7 demute before last strobe", dm, 0);
      pulse_fs();
      chk("R7 demute after MUTE_FS strobes", dm, 1);
      #5 mute = 1'b0;
      #1 chk("R7 demute follows mute", dm, 0);
      go(1);
      #5 mute = 1'b1;
      go(1);
      chk("R7 demute back", dm, 1);

      // Enable drop and return.
      #5 en = 1'b0;
      go(1);
      chk("R6 back to clock-running", ph, 3);
      chk("R6 out_en low", oe, 0);
      chk("R6 clock kept", clks, 1);
      #5 en = 1'b1;
      go(1);
      chk("R6 active again at once", ph, 4);
      chk("R6 demute restarts count", dm, 0);

      // Immediate sleep.
      #5 pwr = 1'b0;
      #1 chk("R2 phase same cycle", ph, 0);
      chk("R2 outputs same cycle", {bus, clks, oe, dm}, 0);
      go(1);
      chk("R2 sleep after edge", ph, 0);

      // Pin-strapped power-up: measure turn-on, bus must stay low.
      begin
         int n;
         bit seen;
         n = 0; seen = 1'b0;
         #5 pwr = 1'b1; mode = 1'b0; en = 1'b1;
         do begin
            go(1);
            n++;
            if (bus) seen = 1'b1;
         end while (!oe && n < 100);
         chk("R9 turn-on cycles", n - 1, W + S + L);
         chk("R9 turn-on in window", int'((n - 1) >= TMIN && (n - 1) <= TMAX), 1);
         chk("R8 bus_ready low in pin mode", seen, 0);
      end

      // Power dropped during wake restarts the sequence; hold without enable.
      #5 pwr = 1'b0;
      go(1);
      #5 pwr = 1'b1; en = 1'b0; mode = 1'b1;
      go(2);
      #5 pwr = 1'b0;
      go(1);
      chk("R2 sleep from wake", ph, 0);
      #5 pwr = 1'b1;
      go(1);
      chk("R3 wake restarted", ph, 1);
      go(W);
      chk("R3 full wake after restart", ph, 2);
      go(S);
      chk("R4 clock-running reached", ph, 3);
      go(L + 5);
      chk("R5 held without enable", ph, 3);
      chk("R5 out_en off while held", oe, 0);
      #5 en = 1'b1;
      go(1);
      chk("R5 active on enable", ph, 4);

      // Random stress against the model.
      for (int i = 0; i < 3000; i++) begin
         #5;
         pwr  = ($urandom % 64) != 0;
         en   = ($urandom % 16) != 0;
         mute = ($urandom % 8) != 0;
         fs   = ($urandom % 3) == 0;
         mode = ($urandom % 2) != 0;
         go(1);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule